// File: doc/BRIEF.md
# Ethernet Status LED Driver

This block turns the link state of an Ethernet port and its transmit and receive activity strobes into four active-low LED drive signals. A 2-bit mode value selects what each of the four pins shows: steady link indications (any link, 10 Mb/s link, 100 Mb/s link, full duplex), blinking activity indications (transmit, receive, either), or combined link-and-activity indications that stay lit on a link and flash off for traffic. The mode is normally supplied once by a configuration loader after power-up; with no loader it stays at mode 3.

Activity is shown as fixed-length blink cycles timed by a one-pulse-per-millisecond tick: a cycle is two equal halves of `HALF_TICKS` ticks each (40 by default). Strobes that arrive while a cycle runs are remembered so that another full cycle follows, and a running cycle is never shortened or restarted. A power-down input forces every pin dark. All outputs are registered.

Top module: `eth_led_driver`

## Requirements
- R1: After reset the mode is 3 and every output is high while no link is present; with a 100 Mb/s full-duplex link and no load the outputs read led_n = 4'b1001 (bit index = pin number).
- R2: A cycle with cfg_load high stores cfg_mode as the mode; the outputs follow the new mode from the second clock edge on.
- R3: Mode 0 shows pin 0 = either-direction activity, pin 1 = 100 Mb/s link, pin 2 = 10 Mb/s link, pin 3 = full duplex.
- R4: Modes 1 and 3 show pin 0 = 10 Mb/s link with activity, pin 1 = 100 Mb/s link with activity, pin 2 = full duplex, pin 3 unused.
- R5: Mode 2 shows pin 0 = transmit activity, pin 1 = any link, pin 2 = receive activity, pin 3 unused.
- R6: Link indications are low while link_up is high and the speed matches (speed_100 = 1 means 100 Mb/s, 0 means 10 Mb/s); the full-duplex pin is low only when link_up and full_duplex are both high; all are high with the link down.
- R7: An activity pin idles high; after a strobe it stays high for HALF_TICKS ticks, then low for HALF_TICKS ticks, then returns high.
- R8: A link-with-activity pin is low while its link is up and idle; after a strobe it stays low for HALF_TICKS ticks then high for HALF_TICKS ticks; with its link down it is high.
- R9: A strobe during a running cycle neither restarts nor shortens it; it causes one further full cycle directly after the current one.
- R10: An unused pin is always high.
- R11: While power_down is high every output is high one edge later, whatever the link and activity state.
- R12: A change of link_up, speed_100 or full_duplex appears at the outputs after exactly one rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ms_tick | input | 1 | One-cycle pulse per millisecond, blink timebase |
| link_up | input | 1 | Link established |
| speed_100 | input | 1 | 1 = 100 Mb/s, 0 = 10 Mb/s |
| full_duplex | input | 1 | Link is full duplex |
| tx_act | input | 1 | One-cycle strobe per transmitted packet |
| rx_act | input | 1 | One-cycle strobe per received packet |
| power_down | input | 1 | Forces all LEDs dark |
| cfg_load | input | 1 | Stores cfg_mode as the mode |
| cfg_mode | input | 2 | Mode value from the configuration loader |
| led_n | output | 4 | Active-low LED drives, bit n = pin n |

## Verification
On every cycle the assertions check that power-down darkens all pins, that an unused pin stays high, that a linked and idle link-with-activity pin is lit, that a loaded mode is taken, that a blink phase holds between ticks and that a strobe inside a cycle is remembered. Only the bench's scenarios show the whole mode table across every link combination, the exact blink phase lengths counted in ticks, the extra cycle caused by a late strobe and the one-edge output latency.

// File: rtl/led_pkg.sv
package led_pkg;

  typedef enum logic [3:0] {
    IND_NONE,
    IND_LINK,
    IND_LINK10,
    IND_LINK100,
    IND_FULL,
    IND_ACT_TX,
    IND_ACT_RX,
    IND_ACT_ANY,
    IND_L10_ACT,
    IND_L100_ACT
  } led_role_e;

  typedef enum logic [1:0] {
    BL_IDLE,
    BL_FIRST,
    BL_SECOND
  } blink_state_e;

  typedef struct packed {
    logic link;
    logic link10;
    logic link100;
    logic full;
    logic tx_dark;
    logic rx_dark;
    logic any_dark;
  } led_status_t;

  // Role of each pin in each mode; modes 1 and 3 share one layout.
  function automatic led_role_e pin_role(input logic [1:0] mode, input logic [1:0] pin);
    led_role_e r;
    r = IND_NONE;
    unique case (mode)
      2'd0: begin
        unique case (pin)
          2'd0: r = IND_ACT_ANY;
          2'd1: r = IND_LINK100;
          2'd2: r = IND_LINK10;
          default: r = IND_FULL;
        endcase
      end
      2'd2: begin
        unique case (pin)
          2'd0: r = IND_ACT_TX;
          2'd1: r = IND_LINK;
          2'd2: r = IND_ACT_RX;
          default: r = IND_NONE;
        endcase
      end
      default: begin
        unique case (pin)
          2'd0: r = IND_L10_ACT;
          2'd1: r = IND_L100_ACT;
          2'd2: r = IND_FULL;
          default: r = IND_NONE;
        endcase
      end
    endcase
    return r;
  endfunction

endpackage

// File: rtl/led_blink_engine.sv
module led_blink_engine
  import led_pkg::*;
#(
  parameter int HALF_TICKS = 40
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic act,
  output logic second_half
);
  localparam int CW = (HALF_TICKS < 2) ? 1 : $clog2(HALF_TICKS);
  localparam logic [CW-1:0] LAST = CW'(HALF_TICKS - 1);

  blink_state_e state;
  logic [CW-1:0] cnt;
  logic          pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= BL_IDLE;
      cnt   <= '0;
      pend  <= 1'b0;
    end else begin
      unique case (state)
        BL_IDLE: begin
          if (act) begin
            state <= BL_FIRST;
            cnt   <= '0;
          end
        end
        BL_FIRST: begin
          if (act) pend <= 1'b1;
          if (tick) begin
            if (cnt == LAST) begin
              state <= BL_SECOND;
              cnt   <= '0;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        default: begin
          if (act) pend <= 1'b1;
          if (tick) begin
            if (cnt == LAST) begin
              cnt <= '0;
              if (pend || act) begin
                state <= BL_FIRST;
                pend  <= 1'b0;
              end else begin
                state <= BL_IDLE;
              end
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
      endcase
    end
  end

  assign second_half = (state == BL_SECOND);

  // R7: a running phase only advances on a tick
  p_phase_holds_r7: assert property (@(posedge clk) disable iff (rst)
    (state != BL_IDLE && !tick && !act) |=> $stable(state) && $stable(cnt));

  // R9: a strobe inside a cycle is remembered or starts the next cycle at once
  p_strobe_kept_r9: assert property (@(posedge clk) disable iff (rst)
    (state != BL_IDLE && act) |=> (pend || state == BL_FIRST));

endmodule

// File: rtl/led_pin_select.sv
module led_pin_select
  import led_pkg::*;
(
  input  led_role_e   role,
  input  led_status_t st,
  output logic        lit
);
  always_comb begin
    unique case (role)
      IND_LINK:     lit = st.link;
      IND_LINK10:   lit = st.link10;
      IND_LINK100:  lit = st.link100;
      IND_FULL:     lit = st.full;
      IND_ACT_TX:   lit = st.tx_dark;
      IND_ACT_RX:   lit = st.rx_dark;
      IND_ACT_ANY:  lit = st.any_dark;
      IND_L10_ACT:  lit = st.link10 && !st.any_dark;
      IND_L100_ACT: lit = st.link100 && !st.any_dark;
      default:      lit = 1'b0;
    endcase
  end
endmodule

// File: rtl/eth_led_driver.sv
module eth_led_driver
  import led_pkg::*;
#(
  parameter int          HALF_TICKS   = 40,
  parameter logic [1:0]  DEFAULT_MODE = 2'd3
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       ms_tick,
  input  logic       link_up,
  input  logic       speed_100,
  input  logic       full_duplex,
  input  logic       tx_act,
  input  logic       rx_act,
  input  logic       power_down,
  input  logic       cfg_load,
  input  logic [1:0] cfg_mode,
  output logic [3:0] led_n
);
  localparam int NUM_PINS = 4;
  localparam int NUM_SRC  = 3;

  logic [1:0]          mode_q;
  logic [NUM_SRC-1:0]  src_act;
  logic [NUM_SRC-1:0]  src_dark;
  logic [NUM_PINS-1:0] lit;
  led_status_t         st;

  always_ff @(posedge clk) begin
    if (rst)           mode_q <= DEFAULT_MODE;
    else if (cfg_load) mode_q <= cfg_mode;
  end

  // source 0: transmit, 1: receive, 2: either
  assign src_act = {tx_act | rx_act, rx_act, tx_act};

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    led_blink_engine #(.HALF_TICKS(HALF_TICKS)) u_eng (
      .clk        (clk),
      .rst        (rst),
      .tick       (ms_tick),
      .act        (src_act[s]),
      .second_half(src_dark[s])
    );
  end

  always_comb begin
    st.link     = link_up;
    st.link10   = link_up && !speed_100;
    st.link100  = link_up && speed_100;
    st.full     = link_up && full_duplex;
    st.tx_dark  = src_dark[0];
    st.rx_dark  = src_dark[1];
    st.any_dark = src_dark[2];
  end

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    led_pin_select u_sel (
      .role(pin_role(mode_q, 2'(p))),
      .st  (st),
      .lit (lit[p])
    );
  end

  always_ff @(posedge clk) begin
    if (rst)             led_n <= '1;
    else if (power_down) led_n <= '1;
    else                 led_n <= ~lit;
  end

  // R11: power-down darkens every pin
  p_pd_dark_r11: assert property (@(posedge clk) disable iff (rst)
    power_down |=> (led_n == 4'hF));

  // R10: pin 3 is unused outside mode 0
  p_unused_high_r10: assert property (@(posedge clk) disable iff (rst)
    (mode_q != 2'd0) |=> led_n[3]);

  // R8: linked and idle link-with-activity pin is lit
  p_linkact_idle_r8: assert property (@(posedge clk) disable iff (rst)
    (mode_q == 2'd1 && link_up && !speed_100 && !src_dark[2] && !power_down)
      |=> !led_n[0]);

  // R2: a load takes the offered mode
  p_cfg_taken_r2: assert property (@(posedge clk) disable iff (rst)
    cfg_load |=> (mode_q == $past(cfg_mode)));

endmodule

// File: tb/eth_led_driver_test.sv
module eth_led_driver_test;
  localparam int PERIOD = 10;
  localparam int HALF   = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ms_tick = 0, link_up = 0, speed_100 = 0, full_duplex = 0;
  logic tx_act = 0, rx_act = 0, power_down = 0, cfg_load = 0;
  logic [1:0] cfg_mode = 2'd0;
  logic [3:0] led_n;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #(PERIOD/2) clk = ~clk;

  eth_led_driver #(.HALF_TICKS(HALF)) uut (
    .clk(clk), .rst(rst), .ms_tick(ms_tick), .link_up(link_up),
    .speed_100(speed_100), .full_duplex(full_duplex), .tx_act(tx_act),
    .rx_act(rx_act), .power_down(power_down), .cfg_load(cfg_load),
    .cfg_mode(cfg_mode), .led_n(led_n)
  );

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [3:0] exp);
    checks++;
    if (led_n !== exp) begin
      fails++;
      $display("FAIL %s: led_n=%b expected %b", req, led_n, exp);
    end
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      ms_tick = 1'b1; cyc(1);
      ms_tick = 1'b0; cyc(1);
    end
  endtask

  task automatic pulse_tx();
    tx_act = 1'b1; cyc(1); tx_act = 1'b0;
  endtask

  task automatic pulse_rx();
    rx_act = 1'b1; cyc(1); rx_act = 1'b0;
  endtask

  task automatic load_mode(input logic [1:0] m);
    cfg_mode = m; cfg_load = 1'b1; cyc(1); cfg_load = 1'b0; cyc(2);
  endtask

  // expected outputs with no activity, from R3..R6 and R10
  function automatic logic [3:0] exp_static(input logic [1:0] m, input logic lu,
                                            input logic s, input logic fd);
    logic l10, l100, full;
    logic [3:0] on;
    l10 = lu & ~s; l100 = lu & s; full = lu & fd;
    case (m)
      2'd0:    on = {full, l10, l100, 1'b0};
      2'd2:    on = {1'b0, 1'b0, lu, 1'b0};
      default: on = {1'b0, full, l100, l10};
    endcase
    return ~on;
  endfunction

  initial begin
    #(PERIOD * 100000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    cyc(3);
    rst = 1'b0;
    cyc(2);
    // R1: reset state, no link
    check("R1 reset dark", 4'hF);
    link_up = 1; speed_100 = 1; full_duplex = 1;
    cyc(2);
    check("R1 default mode 3", 4'b1001);

    // R12: one-edge latency on link change
    speed_100 = 0;
    cyc(1);
    check("R12 latency", exp_static(2'd3, 1, 0, 1));

    // exhaustive mode x link sweep (R2..R6, R10)
    for (int m = 0; m < 4; m++) begin
      load_mode(2'(m));
      for (int c = 0; c < 8; c++) begin
        link_up = c[2]; speed_100 = c[1]; full_duplex = c[0];
        cyc(2);
        case (m)
          0: check("R2 R3 R6 mode0 map", exp_static(2'(m), c[2], c[1], c[0]));
          1: check("R2 R4 R6 R10 mode1 map", exp_static(2'(m), c[2], c[1], c[0]));
          2: check("R2 R5 R6 R10 mode2 map", exp_static(2'(m), c[2], c[1], c[0]));
          default: check("R2 R4 R6 R10 mode3 map", exp_static(2'(m), c[2], c[1], c[0]));
        endcase
      end
    end

    // R7: transmit activity blink in mode 2, link down
    load_mode(2'd2);
    link_up = 0; speed_100 = 0; full_duplex = 0;
    cyc(2);
    pulse_tx();
    cyc(2);
    check("R7 tx first half high", 4'hF);
    ticks(HALF - 1); cyc(1);
    check("R7 tx still first half", 4'hF);
    ticks(1); cyc(1);
    check("R7 tx second half low", 4'b1110);
    ticks(HALF - 1); cyc(1);
    check("R7 tx second half held", 4'b1110);
    ticks(1); cyc(1);
    check("R7 tx back to idle", 4'hF);

    // R7: receive pin independent
    pulse_rx();
    ticks(HALF); cyc(1);
    check("R7 rx second half low", 4'b1011);
    ticks(HALF); cyc(1);
    check("R7 rx idle", 4'hF);

    // R9: strobe in first half does not restart the cycle
    pulse_tx();
    ticks(1);
    pulse_tx();
    ticks(HALF - 1); cyc(1);
    check("R9 not restarted", 4'b1110);
    ticks(HALF); cyc(1);
    check("R9 extra cycle first half", 4'hF);
    ticks(HALF); cyc(1);
    check("R9 extra cycle second half", 4'b1110);
    ticks(HALF); cyc(1);
    check("R9 extra cycle ends", 4'hF);

    // R3: either-direction activity pin in mode 0
    load_mode(2'd0);
    pulse_rx();
    ticks(HALF); cyc(1);
    check("R3 any activity low", 4'b1110);
    ticks(HALF); cyc(1);
    check("R3 any activity idle", 4'hF);

    // R8: link-with-activity in mode 1, 10 Mb/s half duplex
    load_mode(2'd1);
    link_up = 1; speed_100 = 0; full_duplex = 0;
    cyc(2);
    check("R8 linked idle lit", 4'b1110);
    pulse_rx();
    ticks(HALF - 1); cyc(1);
    check("R8 first half lit", 4'b1110);
    ticks(1); cyc(1);
    check("R8 second half dark", 4'hF);
    ticks(HALF); cyc(1);
    check("R8 back to lit", 4'b1110);
    link_up = 0;
    cyc(2);
    check("R8 no link dark", 4'hF);

    // R11: power-down during link and blink
    load_mode(2'd0);
    link_up = 1; speed_100 = 1; full_duplex = 1;
    cyc(2);
    check("R11 before power-down", 4'b0101);
    pulse_tx();
    power_down = 1;
    cyc(1);
    check("R11 forced dark", 4'hF);
    ticks(HALF); cyc(1);
    check("R11 dark through blink", 4'hF);
    power_down = 0;
    ticks(HALF); cyc(2);
    check("R11 released", 4'b0101);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule